// File: doc/BRIEF.md
# Lockstep Three-Stage Pipeline with Bubble Tracking

This block places three fixed arithmetic steps between an upstream queue and a downstream queue. Two pipeline slots sit between the steps, and each slot holds a data word and a valid flag. Every slot moves on the same clock edge, or none of them moves. The block never stalls one stage while another stage moves.

The flags let the pipeline keep shifting while the upstream queue is empty. Empty slots travel toward the output as bubbles and produce no writes downstream. When the last slot is empty, the pipeline keeps shifting even if the downstream queue is full. The block drives the dequeue and enqueue strobes of the two queues itself. It reads the head word of the upstream queue and writes the processed word to the downstream queue.

Top module: `lockstep_pipe`

## Requirements
- R1: After synchronous reset, both slots are empty. With no input available, `in_deq` and `out_enq` are low, even when the output queue is full.
- R2: The pipeline advances in a cycle when `out_not_full` is high or the last slot is empty. Otherwise no slot changes.
- R3: `in_deq` is high exactly in the cycles that advance while `in_not_empty` is high. In such a cycle, the first slot loads step A of `in_data` and becomes valid.
- R4: An advancing cycle with `in_not_empty` low empties the first slot. Two advancing cycles later, that bubble produces no `out_enq`.
- R5: The last slot takes step B of the first slot's contents and copies its valid flag. `out_enq` is high exactly in advancing cycles where the last slot is valid, and `out_data` is then step C of that slot. With W = 16, step A is x+3, step B is x XOR 0x5A5A, and step C is 3·x. All are taken modulo 2^W.
- R6: While `out_not_full` is low and the last slot is valid, `in_deq` and `out_enq` stay low and `out_data` holds its value, whatever `in_not_empty` does.
- R7: Every dequeued word leaves exactly once, in arrival order, with no loss or duplication under any pattern of input gaps and backpressure.
- R8: With `out_not_full` held high, a word dequeued in cycle k is enqueued in cycle k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_not_empty | input | 1 | Upstream queue has a word |
| in_data | input | W | Head word of upstream queue |
| in_deq | output | 1 | Dequeue strobe to upstream queue |
| out_not_full | input | 1 | Downstream queue can accept a word |
| out_enq | output | 1 | Enqueue strobe to downstream queue |
| out_data | output | W | Word written downstream |

## Verification
Both strobes are combinational functions of the current inputs and the last slot's flag. The bench therefore checks them in the same cycle as the stimulus, sampling at the falling edge after it drives the inputs. A dequeued word becomes due on `out_data` two advancing edges later. The bench's behavioural model shifts only on cycles it predicts as advancing, so stalls delay the expected word by exactly the number of stalled cycles. A directed sequence with no backpressure checks the fixed two-cycle latency. A scoreboard queue checks order and completeness over long runs with random gaps and backpressure.

// File: rtl/lockstep_pipe_pkg.sv
`timescale 1ns/1ps
package lockstep_pipe_pkg;
    typedef enum logic [1:0] {
        OP_BIAS   = 2'd0,
        OP_MASK   = 2'd1,
        OP_TRIPLE = 2'd2
    } stage_op_e;

    localparam int unsigned    BIAS_K = 3;
    localparam logic [63:0]    MASK_K = 64'h5A5A_5A5A_5A5A_5A5A;
    localparam int unsigned    NUM_SLOTS = 2;
endpackage

// File: rtl/lp_stage_op.sv
`timescale 1ns/1ps
module lp_stage_op
    import lockstep_pipe_pkg::*;
#(
    parameter int unsigned W  = 16,
    parameter stage_op_e   OP = OP_BIAS
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    generate
        if (OP == OP_BIAS) begin : g_bias
            assign y = x + W'(BIAS_K);
        end else if (OP == OP_MASK) begin : g_mask
            assign y = x ^ MASK_K[W-1:0];
        end else begin : g_triple
            assign y = x + (x << 1);
        end
    endgenerate
endmodule

// File: rtl/lp_slot.sv
`timescale 1ns/1ps
module lp_slot #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         vld_in,
    input  logic [W-1:0] dat_in,
    output logic         vld_q,
    output logic [W-1:0] dat_q
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] dat;
    } slot_t;

    slot_t cur;

    always_ff @(posedge clk) begin
        if (rst)
            cur.vld <= 1'b0;
        else if (adv)
            cur.vld <= vld_in;
    end

    always_ff @(posedge clk) begin
        if (adv)
            cur.dat <= dat_in;
    end

    assign vld_q = cur.vld;
    assign dat_q = cur.dat;

    // R2
    hold_when_stalled_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(vld_q));
endmodule

// File: rtl/lp_ctrl.sv
`timescale 1ns/1ps
module lp_ctrl (
    input  logic in_not_empty,
    input  logic out_not_full,
    input  logic last_vld,
    output logic adv,
    output logic deq,
    output logic enq
);
    always_comb begin
        adv = out_not_full | ~last_vld;
        deq = adv & in_not_empty;
        enq = adv & last_vld;
    end
endmodule

// File: rtl/lockstep_pipe.sv
`timescale 1ns/1ps
module lockstep_pipe
    import lockstep_pipe_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_not_empty,
    input  logic [W-1:0] in_data,
    output logic         in_deq,
    input  logic         out_not_full,
    output logic         out_enq,
    output logic [W-1:0] out_data
);
    localparam int unsigned LAST = NUM_SLOTS - 1;

    logic         adv;
    logic [W-1:0] a_out, b_out;
    logic [W-1:0] s_dat [NUM_SLOTS];
    logic         s_vld [NUM_SLOTS];
    logic [W-1:0] s_din [NUM_SLOTS];
    logic         s_vin [NUM_SLOTS];

    lp_ctrl u_ctrl (
        .in_not_empty (in_not_empty),
        .out_not_full (out_not_full),
        .last_vld     (s_vld[LAST]),
        .adv          (adv),
        .deq          (in_deq),
        .enq          (out_enq)
    );

    lp_stage_op #(.W(W), .OP(OP_BIAS)) u_step_a (.x(in_data), .y(a_out));
    lp_stage_op #(.W(W), .OP(OP_MASK)) u_step_b (.x(s_dat[0]), .y(b_out));
    lp_stage_op #(.W(W), .OP(OP_TRIPLE)) u_step_c (.x(s_dat[LAST]), .y(out_data));

    assign s_din[0] = a_out;
    assign s_vin[0] = in_not_empty;
    assign s_din[1] = b_out;
    assign s_vin[1] = s_vld[0];

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
            lp_slot #(.W(W)) u_slot (
                .clk    (clk),
                .rst    (rst),
                .adv    (adv),
                .vld_in (s_vin[g]),
                .dat_in (s_din[g]),
                .vld_q  (s_vld[g]),
                .dat_q  (s_dat[g])
            );
        end
    endgenerate

    // R3
    deq_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
        in_deq |-> in_not_empty);

    // R5
    enq_needs_room_chk: assert property (@(posedge clk) disable iff (rst)
        out_enq |-> (out_not_full && s_vld[LAST]));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!out_not_full && s_vld[LAST]) |=> (s_vld[LAST] && $stable(out_data)));

    // R4
    bubble_in_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !in_not_empty) |=> !s_vld[0]);
endmodule

// File: tb/lockstep_pipe_tb_top.sv
`timescale 1ns/1ps
module lockstep_pipe_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_not_empty = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_deq;
    logic         out_not_full = 1'b0;
    logic         out_enq;
    logic [W-1:0] out_data;

    always #2.5 clk = ~clk;

    lockstep_pipe #(.W(W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .in_not_empty (in_not_empty),
        .in_data      (in_data),
        .in_deq       (in_deq),
        .out_not_full (out_not_full),
        .out_enq      (out_enq),
        .out_data     (out_data)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit           m_v1 = 1'b0, m_v2 = 1'b0;
    logic [W-1:0] m_x1 = '0, m_x2 = '0;
    logic [W-1:0] sb [$];
    logic [W-1:0] next_x = 16'h0100;
    bit           obs_deq, obs_enq;

    function automatic logic [W-1:0] ref_fn(logic [W-1:0] x);
        logic [W-1:0] a, b;
        a = x + 16'd3;
        b = a ^ 16'h5A5A;
        return b * 16'd3;
    endfunction

    task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(bit ne, bit nf);
        bit adv, edeq, eenq;
        logic [W-1:0] front;
        @(posedge clk);
        #1;
        in_not_empty = ne;
        out_not_full = nf;
        in_data      = next_x;
        @(negedge clk);
        adv  = nf || !m_v2;
        edeq = adv && ne;
        eenq = adv && m_v2;
        obs_deq = in_deq;
        obs_enq = out_enq;
        chk(in_deq === edeq, (!adv) ? "R6 in_deq" : "R3 in_deq", {15'b0, in_deq}, {15'b0, edeq});
        chk(out_enq === eenq, (!adv) ? "R6 out_enq" : "R5 out_enq", {15'b0, out_enq}, {15'b0, eenq});
        if (m_v2)
            chk(out_data === ref_fn(m_x2), "R5 out_data", out_data, ref_fn(m_x2));
        if (out_enq) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R7 unexpected enqueue", out_data, '0);
            end else begin
                front = sb.pop_front();
                chk(out_data === front, "R7 order", out_data, front);
            end
        end
        if (edeq) sb.push_back(ref_fn(next_x));
        if (adv) begin
            m_x2 = m_x1;
            m_v2 = m_v1;
            if (ne) begin
                m_x1 = next_x;
                m_v1 = 1'b1;
                next_x = next_x + 16'd7;
            end else begin
                m_v1 = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state, nothing offered, output queue full
        chk(in_deq === 1'b0, "R1 in_deq", {15'b0, in_deq}, '0);
        chk(out_enq === 1'b0, "R1 out_enq", {15'b0, out_enq}, '0);

        // R1/R2: empty slots let input in despite a full output queue
        step(1, 0);
        chk(obs_deq === 1'b1, "R1 deq into empty pipe", {15'b0, obs_deq}, 16'd1);
        step(1, 0);
        step(1, 0);
        // R6: last slot valid, output full -> frozen
        for (int i = 0; i < 4; i++) begin
            step(i[0], 0);
            chk(obs_deq === 1'b0, "R6 frozen deq", {15'b0, obs_deq}, '0);
        end
        for (int i = 0; i < 4; i++) step(0, 1);

        // R8: two-cycle latency without backpressure
        step(1, 1);
        chk(obs_deq === 1'b1, "R8 deq", {15'b0, obs_deq}, 16'd1);
        step(0, 1);
        chk(obs_enq === 1'b0, "R8 not early", {15'b0, obs_enq}, '0);
        step(0, 1);
        chk(obs_enq === 1'b1, "R8 enq at k+2", {15'b0, obs_enq}, 16'd1);
        // R4: bubbles produce no enqueue
        step(0, 1);
        chk(obs_enq === 1'b0, "R4 bubble", {15'b0, obs_enq}, '0);
        step(0, 1);
        chk(obs_enq === 1'b0, "R4 bubble", {15'b0, obs_enq}, '0);

        // Alternating gaps
        for (int i = 0; i < 20; i++) step(i[0], 1);

        // R7: random gaps and backpressure at several densities
        for (int p = 1; p <= 4; p++) begin
            for (int i = 0; i < 1000; i++)
                step(($urandom_range(0, 4) < p), ($urandom_range(0, 4) < 5 - p));
        end

        for (int i = 0; i < 6; i++) step(0, 1);
        chk(sb.size() == 0, "R7 all words delivered", 16'(sb.size()), '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule